// File: doc/BRIEF.md
# Mode-Switchable Three-Port Parallel Interface

This block is a memory-mapped parallel I/O peripheral with three 8-bit ports, called A, B and C. A small processor-style bus reaches eight registers through a 3-bit register select. The bus signals are a chip select, a read/write strobe, write data, and read data with its own output enable. Each port has a data latch and a direction register. A pin drives its latched value when its direction bit is 1. Reading a port's data address returns the live pin levels rather than the latch.

Bit 0 of the control register chooses the mode.
- **Mode 0:** port C is a plain I/O port like A and B.
- **Mode 1:** port C hands its pins to a separate interrupt and handshake unit.
  - The top three pins (bit 7 = CB, bit 6 = CA, bit 5 = interrupt request) are always driven from that unit's control lines.
  - The low five pins are always inputs.
  - The direction-C address then reaches an interrupt mask register instead.

The control and mask registers are exported to the interrupt unit. The unit's active-interrupt status is read back through the last address.

Top module: `tri_port_pio`

## Requirements
- R1: After a synchronous active-high reset, the following hold:
  - every direction register, data latch, the control register and the mask register is zero;
  - every pad output enable is 0;
  - mode 0 is selected.
- R2: A register is written at a rising clock edge only when `cs`=1 and `rw`=0. A cycle with `cs`=0, or with `rw`=1, changes no register.
- R3: A direction bit of 0 gives a pad output enable of 0 for that pin. A direction bit of 1 gives an enable of 1. The pad output vector of a port equals the last value written to its data address.
- R4: A read of address 0, 1 or 2 (port A, B, C data) returns the pad input levels of that port, not the data latch.
- R5: The bus output enable `d_oe` is 1 exactly when `cs`=1 and `rw`=1. Reads of address 3 (direction A), 4 (direction B) and 6 (control) return the stored value, and the control register also appears on `ctl_o`.
- R6: With control bit 0 equal to 0, port C behaves as general-purpose I/O, and address 5 reads and writes direction C.
- R7: With control bit 0 equal to 1, the following hold whatever direction C holds:
  - `pc_oe` is 8'hE0;
  - `pc_out[7:5]` equals `hs_ctl_i[2:0]`, with bit 7 taking `hs_ctl_i[2]`.
- R8: With control bit 0 equal to 1, address 5 reads and writes the 5-bit interrupt mask (zero-extended on read, also on `imask_o`). Direction C is left untouched and takes effect again on return to mode 0.
- R9: A read of address 7 returns `aint_i` zero-extended. A write to address 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 3 | Register select |
| d_in | input | 8 | Write data |
| d_out | output | 8 | Read data |
| d_oe | output | 1 | Read data output enable |
| pa_in | input | 8 | Port A pad input levels |
| pa_out | output | 8 | Port A pad output values |
| pa_oe | output | 8 | Port A pad output enables |
| pb_in | input | 8 | Port B pad input levels |
| pb_out | output | 8 | Port B pad output values |
| pb_oe | output | 8 | Port B pad output enables |
| pc_in | input | 8 | Port C pad input levels |
| pc_out | output | 8 | Port C pad output values |
| pc_oe | output | 8 | Port C pad output enables |
| hs_ctl_i | input | 3 | CB, CA and interrupt-request levels from the interrupt unit |
| aint_i | input | 5 | Active-interrupt status from the interrupt unit |
| ctl_o | output | 8 | Control register contents |
| imask_o | output | 5 | Interrupt mask register contents |

## Verification
The bench builds the block with the default width of 8. That leaves three handshake lines and five interrupt lines, so the mode-1 override covers exactly pins 7 to 5 and the mask register is five bits wide. With these values every address can be reached in both modes. A direction-C value that conflicts with the forced enables can be loaded before the mode switch and then shown to return intact afterwards.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int NPORT    = 3;
  localparam int HS_LINES = 3;
  localparam int MODE_BIT = 0;
  typedef enum logic [2:0] {
    RS_DATA = 3'd0, RS_DATB = 3'd1, RS_DATC = 3'd2,
    RS_DIRA = 3'd3, RS_DIRB = 3'd4, RS_DIRC = 3'd5,
    RS_CTL  = 3'd6, RS_AINT = 3'd7
  } rsel_e;
endpackage

// File: rtl/tpp_regs.sv
module tpp_regs
  import tpp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NINT = DW - HS_LINES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [2:0]                 rs,
  input  logic [DW-1:0]              wd,
  output logic [NPORT-1:0][DW-1:0]   dat_q,
  output logic [NPORT-1:0][DW-1:0]   dir_q,
  output logic [DW-1:0]              ctl_q,
  output logic [NINT-1:0]            mask_q
);
  logic mode;
  assign mode = ctl_q[MODE_BIT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam bit IS_C = (p == NPORT - 1);
    logic dat_sel, dir_sel;
    assign dat_sel = we && (rs == 3'(p));
    assign dir_sel = we && (rs == 3'(NPORT + p)) && !(IS_C && mode);

    always_ff @(posedge clk) begin
      if (rst) begin
        dat_q[p] <= '0;
        dir_q[p] <= '0;
      end else begin
        if (dat_sel) dat_q[p] <= wd;
        if (dir_sel) dir_q[p] <= wd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      mask_q <= '0;
    end else begin
      if (we && rs == RS_CTL) ctl_q <= wd;
      if (we && rs == RS_DIRC && mode) mask_q <= wd[NINT-1:0];
    end
  end

  // R8
  dirc_keep_chk: assert property (@(posedge clk) disable iff (rst)
    mode |=> (dir_q[NPORT-1] == $past(dir_q[NPORT-1])));
  // R6
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |=> (mask_q == $past(mask_q)));
  // R9
  aint_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (rs == RS_AINT) |=> (ctl_q == $past(ctl_q)));
endmodule

// File: rtl/tpp_pin_drv.sv
module tpp_pin_drv
  import tpp_pkg::*;
#(
  parameter int DW  = 8,
  parameter bit OVR = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_i,
  input  logic [HS_LINES-1:0] hs_i,
  input  logic [DW-1:0]       dat_i,
  input  logic [DW-1:0]       dir_i,
  output logic [DW-1:0]       out_o,
  output logic [DW-1:0]       oe_o
);
  localparam int NLOW = DW - HS_LINES;

  if (OVR) begin : g_ovr
    always_comb begin
      if (mode_i) begin
        out_o = {hs_i, dat_i[NLOW-1:0]};
        oe_o  = {{HS_LINES{1'b1}}, {NLOW{1'b0}}};
      end else begin
        out_o = dat_i;
        oe_o  = dir_i;
      end
    end
    // R7
    ovr_oe_chk: assert property (@(posedge clk) disable iff (rst)
      mode_i |-> (oe_o[DW-1 -: HS_LINES] == '1 && oe_o[NLOW-1:0] == '0
                  && out_o[DW-1 -: HS_LINES] == hs_i));
  end else begin : g_plain
    logic unused_in;
    assign unused_in = ^{mode_i, hs_i};
    assign out_o = dat_i;
    assign oe_o  = dir_i;
  end

  // R3
  dir_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_i |-> (oe_o == dir_i && out_o == dat_i));
endmodule

// File: rtl/tpp_rd_mux.sv
module tpp_rd_mux
  import tpp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NINT = DW - HS_LINES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs,
  input  logic                     rw,
  input  logic [2:0]               rs,
  input  logic [NPORT-1:0][DW-1:0] pin_i,
  input  logic [NPORT-1:0][DW-1:0] dir_i,
  input  logic [DW-1:0]            ctl_i,
  input  logic [NINT-1:0]          mask_i,
  input  logic [NINT-1:0]          aint_i,
  output logic [DW-1:0]            d_out,
  output logic                     d_oe
);
  logic mode;
  assign mode = ctl_i[MODE_BIT];
  assign d_oe = cs && rw;

  always_comb begin
    unique case (rsel_e'(rs))
      RS_DATA: d_out = pin_i[0];
      RS_DATB: d_out = pin_i[1];
      RS_DATC: d_out = pin_i[2];
      RS_DIRA: d_out = dir_i[0];
      RS_DIRB: d_out = dir_i[1];
      RS_DIRC: d_out = mode ? {{(DW-NINT){1'b0}}, mask_i} : dir_i[2];
      RS_CTL:  d_out = ctl_i;
      RS_AINT: d_out = {{(DW-NINT){1'b0}}, aint_i};
      default: d_out = '0;
    endcase
  end

  // R5
  bus_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |-> !d_oe);
  // R4
  pin_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rs == RS_DATA) |-> (d_out == pin_i[0]));
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import tpp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NINT = DW - HS_LINES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs,
  input  logic                rw,
  input  logic [2:0]          rs,
  input  logic [DW-1:0]       d_in,
  output logic [DW-1:0]       d_out,
  output logic                d_oe,
  input  logic [DW-1:0]       pa_in,
  output logic [DW-1:0]       pa_out,
  output logic [DW-1:0]       pa_oe,
  input  logic [DW-1:0]       pb_in,
  output logic [DW-1:0]       pb_out,
  output logic [DW-1:0]       pb_oe,
  input  logic [DW-1:0]       pc_in,
  output logic [DW-1:0]       pc_out,
  output logic [DW-1:0]       pc_oe,
  input  logic [HS_LINES-1:0] hs_ctl_i,
  input  logic [NINT-1:0]     aint_i,
  output logic [DW-1:0]       ctl_o,
  output logic [NINT-1:0]     imask_o
);
  logic                     we;
  logic [NPORT-1:0][DW-1:0] dat_q, dir_q, pin_in, pin_out, pin_oe;
  logic [DW-1:0]            ctl_q;
  logic [NINT-1:0]          mask_q;

  assign we      = cs && !rw;
  assign pin_in  = {pc_in, pb_in, pa_in};
  assign ctl_o   = ctl_q;
  assign imask_o = mask_q;

  tpp_regs #(.DW(DW), .NINT(NINT)) u_regs (
    .clk(clk), .rst(rst), .we(we), .rs(rs), .wd(d_in),
    .dat_q(dat_q), .dir_q(dir_q), .ctl_q(ctl_q), .mask_q(mask_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_drv
    tpp_pin_drv #(.DW(DW), .OVR(p == NPORT - 1)) u_drv (
      .clk(clk), .rst(rst), .mode_i(ctl_q[MODE_BIT]), .hs_i(hs_ctl_i),
      .dat_i(dat_q[p]), .dir_i(dir_q[p]),
      .out_o(pin_out[p]), .oe_o(pin_oe[p])
    );
  end

  assign pa_out = pin_out[0];
  assign pb_out = pin_out[1];
  assign pc_out = pin_out[2];
  assign pa_oe  = pin_oe[0];
  assign pb_oe  = pin_oe[1];
  assign pc_oe  = pin_oe[2];

  tpp_rd_mux #(.DW(DW), .NINT(NINT)) u_rd (
    .clk(clk), .rst(rst), .cs(cs), .rw(rw), .rs(rs),
    .pin_i(pin_in), .dir_i(dir_q), .ctl_i(ctl_q), .mask_i(mask_q),
    .aint_i(aint_i), .d_out(d_out), .d_oe(d_oe)
  );

  // R2
  no_cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (ctl_o == $past(ctl_o) && imask_o == $past(imask_o)));
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (ctl_o == '0 && pa_oe == '0 && pb_oe == '0 && pc_oe == '0));
endmodule

// File: tb/sim_tri_port_pio.sv
module sim_tri_port_pio;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, cs = 0, rw = 1;
  logic [2:0] rs = '0;
  logic [7:0] d_in = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [2:0] hs_ctl_i = '0;
  logic [4:0] aint_i = '0;
  logic [7:0] d_out, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe, ctl_o;
  logic d_oe;
  logic [4:0] imask_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_port_pio u0 (
    .clk(clk), .rst(rst), .cs(cs), .rw(rw), .rs(rs), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .hs_ctl_i(hs_ctl_i), .aint_i(aint_i), .ctl_o(ctl_o), .imask_o(imask_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per selected read cycle
  always @(negedge clk) begin
    if (cs && rw && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " d_oe"}, {7'd0, d_oe}, 8'd1);
      chk(e.tag, d_out, e.exp);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] v, input logic sel = 1'b1,
                    input logic r = 1'b0);
    @(posedge clk); #1;
    cs = sel; rw = r; rs = a; d_in = v;
    @(posedge clk); #1;
    cs = 0; rw = 1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    cs = 1; rw = 1; rs = a;
    @(posedge clk); #1;
    cs = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 ctl_o", ctl_o, 8'h00);
    chk("R1 imask", {3'd0, imask_o}, 8'h00);
    chk("R5 idle d_oe", {7'd0, d_oe}, 8'h00);
    rd(3'd3, 8'h00, "R1 dirA");
    rd(3'd5, 8'h00, "R1 dirC");
    rd(3'd6, 8'h00, "R1 ctl");

    // R2: deselected write and read-strobe write do nothing
    wr(3'd3, 8'hFF, 1'b0);
    chk("R2 no cs", pa_oe, 8'h00);
    wr(3'd3, 8'hFF, 1'b1, 1'b1);
    chk("R2 rw read", pa_oe, 8'h00);

    // R3 direction and output values
    wr(3'd3, 8'hF0);
    wr(3'd0, 8'hA5);
    chk("R3 pa_oe", pa_oe, 8'hF0);
    chk("R3 pa_out", pa_out, 8'hA5);
    wr(3'd4, 8'hFF);
    wr(3'd1, 8'h00);
    chk("R3 pb_oe", pb_oe, 8'hFF);
    chk("R3 pb_out", pb_out, 8'h00);

    // R4 reads return pins
    pa_in = 8'h3C; pb_in = 8'h81; pc_in = 8'h5A;
    rd(3'd0, 8'h3C, "R4 port A pins");
    rd(3'd1, 8'h81, "R4 port B pins");
    rd(3'd2, 8'h5A, "R4 port C pins");

    // R5 stored registers
    rd(3'd3, 8'hF0, "R5 dirA");
    rd(3'd4, 8'hFF, "R5 dirB");
    wr(3'd6, 8'h6A);
    rd(3'd6, 8'h6A, "R5 ctl");
    chk("R5 ctl_o", ctl_o, 8'h6A);

    // R6 mode 0 port C
    wr(3'd5, 8'h0F);
    wr(3'd2, 8'h33);
    chk("R6 pc_oe", pc_oe, 8'h0F);
    chk("R6 pc_out", pc_out, 8'h33);
    rd(3'd5, 8'h0F, "R6 dirC");
    chk("R6 mask untouched", {3'd0, imask_o}, 8'h00);

    // R7 mode 1 override
    hs_ctl_i = 3'b101;
    wr(3'd6, 8'h6B);
    chk("R7 pc_oe", pc_oe, 8'hE0);
    chk("R7 pc_out hi", {5'd0, pc_out[7:5]}, 8'h05);
    hs_ctl_i = 3'b010;
    #1 chk("R7 pc_out follow", {5'd0, pc_out[7:5]}, 8'h02);

    // R8 mask at dirC address
    wr(3'd5, 8'h15);
    chk("R8 imask_o", {3'd0, imask_o}, 8'h15);
    rd(3'd5, 8'h15, "R8 mask read");
    chk("R8 pc_oe still forced", pc_oe, 8'hE0);
    wr(3'd6, 8'h6A);
    rd(3'd5, 8'h0F, "R8 dirC restored");
    chk("R8 pc_oe restored", pc_oe, 8'h0F);
    chk("R8 mask kept", {3'd0, imask_o}, 8'h15);

    // R9 active interrupt address
    aint_i = 5'h13;
    rd(3'd7, 8'h13, "R9 aint read");
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h13, "R9 aint after write");
    chk("R9 ctl unchanged", ctl_o, 8'h6A);
    rd(3'd3, 8'hF0, "R9 dirA unchanged");

    repeat (3) @(posedge clk);
    chk("scoreboard drained", 8'(sb.size()), 8'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule